// File: doc/BRIEF.md
# Conversion Trigger and Interrupt Latch

This block decides when an analog-to-digital conversion begins and records external trigger events for interrupt signalling. A small control register holds a 2-bit start-source code. The code selects software-only starts, starts on each rising edge of an external trigger pin, or starts on each pulse from an on-chip pacer. A software start strobe works in every mode. Every accepted start request gives a single-cycle `conv_start` pulse. A request that arrives while the converter reports busy is dropped and is not queued.

The external trigger pin is asynchronous. It passes through a two-flop synchroniser, and its rising edges are detected after that. Each rising edge also sets a sticky event flag, whatever source mode is selected. The flag stays set until a write strobe to the status location clears it, so a short pulse is never missed. The flag is routed to one of several interrupt request lines, chosen by a 3-bit level field in the control register, when the interrupt enable bit is set. Only lines 2 to 7 can be driven. The same register carries a DMA-request enable, which is passed straight to an output.

Top module: `trig_irq_ctl`

## Requirements
- R1: `sw_start_we` sampled high while `conv_busy` is low gives `conv_start` high for exactly the next cycle, in every source mode. With source code 00 or 01 (control bits 1:0), no other input causes a start.
- R2: With source code 10, each rising edge of `trig_pin` gives one `conv_start` pulse. The pulse is high in the cycle after the third rising clock edge that samples the pin high. A falling edge of the pin gives no start.
- R3: With source code 11, each clock edge that samples `pacer_pulse` high (and `conv_busy` low) gives `conv_start` high in the next cycle, so back-to-back pacer cycles give back-to-back starts.
- R4: Any start request sampled while `conv_busy` is high is dropped: `conv_start` stays low, and no start follows later for that request.
- R5: A rising edge of `trig_pin` sets `int_flag` in every source mode, in the same cycle that R2 gives for the start pulse.
- R6: `int_flag` stays set until `stat_clr_we` is sampled high, and it reads 0 in the next cycle. A clear wins over a trigger edge detected at the same clock edge, and that edge is lost.
- R7: A `ctl_we` strobe stores all eight bits of `ctl_wdata`, which appear on `ctl_rdata` in the next cycle. The reset value is 0. The layout is: bit 7 interrupt enable, bits 6:4 interrupt level, bit 3 unused (stored but without effect), bit 2 DMA enable, bits 1:0 source code.
- R8: `dma_en` equals control bit 2.
- R9: `irq_lines[L]` is high only when control bit 7 is 1, `int_flag` is 1, the level field equals L, and L is 2 or more. Level codes 0 and 1 drive no line, and at most one line is high.
- R10: A trigger pulse held high across two consecutive rising clock edges sets `int_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| sw_start_we | input | 1 | Software start strobe (a write to the data location) |
| stat_clr_we | input | 1 | Status write strobe; clears the event flag |
| pacer_pulse | input | 1 | Pacer output pulse, one cycle wide |
| trig_pin | input | 1 | Asynchronous external trigger |
| conv_busy | input | 1 | Converter busy indication |
| ctl_rdata | output | 8 | Control register read-back |
| conv_start | output | 1 | Single-cycle start-conversion pulse |
| int_flag | output | 1 | Sticky trigger event flag |
| irq_lines | output | 8 | Interrupt request lines, one bit per bus level |
| dma_en | output | 1 | DMA-request enable |

## Verification
Each of the three stimuli (software strobe, pacer pulse and trigger edge) is applied under all four source codes, with busy both low and high. This tells apart a wrong source decode, a start that leaks through in the wrong mode, and a busy gate that queues instead of dropping. All 256 control values are swept twice, with the flag set and then with it clear. This checks read-back, the DMA bit and the interrupt line for every level code, and it shows a wrong level mapping or a drive on lines 0 and 1. Separate sequences apply back-to-back pacer pulses, a second edge while the flag is set, a clear that lands on the same edge as a trigger, a minimum-width pulse and a falling edge. These show wrong stickiness, wrong clear priority and wrong edge polarity.

// File: rtl/trg_pkg.sv
package trg_pkg;
   // start-source code in control bits 1:0
   typedef enum logic [1:0] {
      SRC_SOFT_A = 2'b00,
      SRC_SOFT_B = 2'b01,
      SRC_EXTERN = 2'b10,
      SRC_PACER  = 2'b11
   } trg_src_e;

   localparam int SRC_W   = 2;
   localparam int DMA_BIT = 2;
   localparam int LVL_LSB = 4;
endpackage

// File: rtl/trg_edge_sync.sv
module trg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   // STAGES synchroniser flops plus one history flop for the edge
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], async_in};
   end

   assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/trg_start_sel.sv
module trg_start_sel
   import trg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  trg_src_e src,
   input  logic     sw_req,
   input  logic     ext_rise,
   input  logic     pacer,
   input  logic     busy,
   output logic     start
);
   logic hw_req;
   logic any_req;

   always_comb begin
      unique case (src)
         SRC_EXTERN: hw_req = ext_rise;
         SRC_PACER:  hw_req = pacer;
         default:    hw_req = 1'b0;
      endcase
   end

   assign any_req = sw_req | hw_req;

   always_ff @(posedge clk) begin
      if (!rst_n) start <= 1'b0;
      else        start <= any_req & ~busy;
   end
endmodule

// File: rtl/trg_int_latch.sv
module trg_int_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_evt,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (clr_evt) flag <= 1'b0;
      else if (set_evt) flag <= 1'b1;
   end
endmodule

// File: rtl/trg_irq_map.sv
module trg_irq_map #(
   parameter int LEVEL_W  = 3,
   parameter int LOW_LINE = 2,
   localparam int NUM_LINES = 1 << LEVEL_W
) (
   input  logic                 enable,
   input  logic                 flag,
   input  logic [LEVEL_W-1:0]   level,
   output logic [NUM_LINES-1:0] lines
);
   for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
      if (k < LOW_LINE) begin : g_blocked
         assign lines[k] = 1'b0;
      end else begin : g_live
         assign lines[k] = enable & flag & (level == LEVEL_W'(k));
      end
   end
endmodule

// File: rtl/trig_irq_ctl.sv
module trig_irq_ctl
   import trg_pkg::*;
#(
   parameter int LEVEL_W     = 3,
   parameter int LOW_LINE    = 2,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_LINES  = 1 << LEVEL_W,
   localparam int CTL_W      = LVL_LSB + LEVEL_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic [CTL_W-1:0]     ctl_wdata,
   input  logic                 sw_start_we,
   input  logic                 stat_clr_we,
   input  logic                 pacer_pulse,
   input  logic                 trig_pin,
   input  logic                 conv_busy,
   output logic [CTL_W-1:0]     ctl_rdata,
   output logic                 conv_start,
   output logic                 int_flag,
   output logic [NUM_LINES-1:0] irq_lines,
   output logic                 dma_en
);
   localparam int IE_BIT = CTL_W - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("trig_irq_ctl: SYNC_STAGES must be at least 2");
   end
   if (LOW_LINE < 0 || LOW_LINE >= NUM_LINES) begin : g_bad_low
      $error("trig_irq_ctl: LOW_LINE out of range");
   end
   if (LVL_LSB <= DMA_BIT || DMA_BIT < SRC_W) begin : g_bad_layout
      $error("trig_irq_ctl: control fields overlap");
   end

   logic [CTL_W-1:0] ctl_q;
   logic             ext_rise;

   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_we) ctl_q <= ctl_wdata;
   end

   assign ctl_rdata = ctl_q;
   assign dma_en    = ctl_q[DMA_BIT];

   trg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (trig_pin),
      .rise     (ext_rise)
   );

   trg_start_sel u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (trg_src_e'(ctl_q[SRC_W-1:0])),
      .sw_req   (sw_start_we),
      .ext_rise (ext_rise),
      .pacer    (pacer_pulse),
      .busy     (conv_busy),
      .start    (conv_start)
   );

   trg_int_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (ext_rise),
      .clr_evt (stat_clr_we),
      .flag    (int_flag)
   );

   trg_irq_map #(.LEVEL_W(LEVEL_W), .LOW_LINE(LOW_LINE)) u_map (
      .enable (ctl_q[IE_BIT]),
      .flag   (int_flag),
      .level  (ctl_q[LVL_LSB +: LEVEL_W]),
      .lines  (irq_lines)
   );
endmodule

// File: rtl/trig_irq_ctl_chk.sv
module trig_irq_ctl_chk #(
   parameter int CTL_W     = 8,
   parameter int NUM_LINES = 8,
   parameter int LOW_LINE  = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ctl_we,
   input logic [CTL_W-1:0]     ctl_wdata,
   input logic                 sw_start_we,
   input logic                 stat_clr_we,
   input logic                 pacer_pulse,
   input logic                 trig_pin,
   input logic                 conv_busy,
   input logic [CTL_W-1:0]     ctl_rdata,
   input logic                 conv_start,
   input logic                 int_flag,
   input logic [NUM_LINES-1:0] irq_lines,
   input logic                 dma_en
);
   localparam logic [NUM_LINES-1:0] LOW_MASK = NUM_LINES'((1 << LOW_LINE) - 1);

   assert_sw_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sw_start_we && !conv_busy |=> conv_start);

   assert_soft_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[1] && !sw_start_we |=> !conv_start);

   assert_pacer_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[1:0] == 2'b11 && pacer_pulse && !conv_busy |=> conv_start);

   assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_busy |=> !conv_start);

   assert_flag_from_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_flag) |-> $past(trig_pin, 2));

   assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr_we |=> !int_flag);

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int_flag && !stat_clr_we |=> int_flag);

   assert_ctl_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> ctl_rdata == $past(ctl_wdata));

   assert_dma_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> dma_en == $past(ctl_wdata[2]));

   assert_one_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_lines));

   assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      |irq_lines |-> int_flag && ctl_rdata[CTL_W-1]);

   assert_low_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lines & LOW_MASK) == '0);
endmodule

bind trig_irq_ctl trig_irq_ctl_chk #(
   .CTL_W     (CTL_W),
   .NUM_LINES (NUM_LINES),
   .LOW_LINE  (LOW_LINE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_we      (ctl_we),
   .ctl_wdata   (ctl_wdata),
   .sw_start_we (sw_start_we),
   .stat_clr_we (stat_clr_we),
   .pacer_pulse (pacer_pulse),
   .trig_pin    (trig_pin),
   .conv_busy   (conv_busy),
   .ctl_rdata   (ctl_rdata),
   .conv_start  (conv_start),
   .int_flag    (int_flag),
   .irq_lines   (irq_lines),
   .dma_en      (dma_en)
);

// File: tb/trig_irq_ctl_test.sv
module trig_irq_ctl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       sw_start_we = 1'b0;
   logic       stat_clr_we = 1'b0;
   logic       pacer_pulse = 1'b0;
   logic       trig_pin = 1'b0;
   logic       conv_busy = 1'b0;
   logic [7:0] ctl_rdata;
   logic       conv_start;
   logic       int_flag;
   logic [7:0] irq_lines;
   logic       dma_en;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   trig_irq_ctl uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_we      (ctl_we),
      .ctl_wdata   (ctl_wdata),
      .sw_start_we (sw_start_we),
      .stat_clr_we (stat_clr_we),
      .pacer_pulse (pacer_pulse),
      .trig_pin    (trig_pin),
      .conv_busy   (conv_busy),
      .ctl_rdata   (ctl_rdata),
      .conv_start  (conv_start),
      .int_flag    (int_flag),
      .irq_lines   (irq_lines),
      .dma_en      (dma_en)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_ctl(input logic [7:0] v);
      ctl_we = 1'b1;
      ctl_wdata = v;
      step();
      ctl_we = 1'b0;
   endtask

   task automatic clear_flag();
      stat_clr_we = 1'b1;
      step();
      stat_clr_we = 1'b0;
   endtask

   // raises the pin, checks the start pulse and flag, then lowers the pin
   task automatic trig_edge(input string req, input logic exp_start);
      trig_pin = 1'b1;
      step();
      chk(req, "no start one edge after pin", 32'(conv_start), 0);
      step();
      chk(req, "no start two edges after pin", 32'(conv_start), 0);
      step();
      chk(req, "start on third edge", 32'(conv_start), 32'(exp_start));
      chk("R5", "flag set with edge", 32'(int_flag), 1);
      step();
      chk(req, "start lasts one cycle", 32'(conv_start), 0);
      trig_pin = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R2", "falling edge gives no start", 32'(conv_start), 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // reset state
      chk("R7", "reset ctl", 32'(ctl_rdata), 0);
      chk("R1", "reset start", 32'(conv_start), 0);
      chk("R6", "reset flag", 32'(int_flag), 0);
      chk("R9", "reset irq", 32'(irq_lines), 0);
      chk("R8", "reset dma", 32'(dma_en), 0);

      // every stimulus under every source code, idle and busy
      for (int src = 0; src < 4; src++) begin
         for (int busy = 0; busy < 2; busy++) begin
            write_ctl(8'(src));
            clear_flag();
            // software strobe: R1 all modes, R4 when busy
            conv_busy = 1'(busy);
            sw_start_we = 1'b1;
            step();
            sw_start_we = 1'b0;
            chk(busy ? "R4" : "R1", "software start", 32'(conv_start), 32'(busy == 0));
            step();
            chk("R4", "no deferred software start", 32'(conv_start), 0);
            // pacer pulse: R3 only in code 11
            pacer_pulse = 1'b1;
            step();
            pacer_pulse = 1'b0;
            chk(src == 3 ? "R3" : "R1", "pacer start", 32'(conv_start),
                32'(src == 3 && busy == 0));
            step();
            chk("R4", "no deferred pacer start", 32'(conv_start), 0);
            // trigger edge: R2 only in code 10
            trig_edge(src == 2 ? "R2" : "R1", 1'(src == 2 && busy == 0));
            conv_busy = 1'b0;
            step();
            chk("R4", "no deferred trigger start", 32'(conv_start), 0);
         end
      end

      // back-to-back pacer pulses, bit 3 set without effect
      write_ctl(8'h0B);
      pacer_pulse = 1'b1;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R3", "back-to-back pacer start (bit 3 set, R7)", 32'(conv_start), 1);
      end
      pacer_pulse = 1'b0;
      step();
      chk("R3", "pacer stops", 32'(conv_start), 0);

      // stickiness: flag holds, a second edge keeps it
      write_ctl(8'h00);
      clear_flag();
      chk("R6", "flag cleared", 32'(int_flag), 0);
      trig_edge("R1", 1'b0);
      repeat (5) step();
      chk("R6", "flag holds", 32'(int_flag), 1);
      trig_edge("R1", 1'b0);
      chk("R6", "flag holds after second edge", 32'(int_flag), 1);
      clear_flag();
      chk("R6", "clear drops flag", 32'(int_flag), 0);

      // clear on the same edge as a detected rise
      trig_pin = 1'b1;
      step();
      step();
      stat_clr_we = 1'b1;
      step();
      stat_clr_we = 1'b0;
      chk("R6", "clear wins over coinciding edge", 32'(int_flag), 0);
      step();
      chk("R6", "coinciding edge lost", 32'(int_flag), 0);
      trig_pin = 1'b0;
      repeat (3) step();

      // minimum pulse across two clock edges
      trig_pin = 1'b1;
      step();
      step();
      trig_pin = 1'b0;
      step();
      chk("R10", "two-edge pulse latched", 32'(int_flag), 1);
      repeat (3) step();

      // all control values with flag set
      for (int v = 0; v < 256; v++) begin
         logic [7:0] exp_irq;
         write_ctl(8'(v));
         exp_irq = (v[7] && v[6:4] >= 2) ? 8'(1 << v[6:4]) : 8'h00;
         chk("R7", "ctl read-back", 32'(ctl_rdata), 32'(v));
         chk("R8", "dma enable", 32'(dma_en), 32'(v[2]));
         chk("R9", "irq line, flag set", 32'(irq_lines), 32'(exp_irq));
      end

      // all control values with flag clear
      clear_flag();
      for (int v = 0; v < 256; v++) begin
         write_ctl(8'(v));
         chk("R9", "irq line, flag clear", 32'(irq_lines), 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule